// File: doc/BRIEF.md
# Dithered 12-bit PWM channel

This block drives one pulse-width-modulated output from a 12-bit duty word. A period of the output is built from 16 subsections of 256 time steps each, and one time step passes on every clock cycle in which the `tick` clock-enable is high. The upper eight bits of the duty word set how many steps each subsection spends high, always starting at the first step of the subsection. The lower four bits pick a set of subsections that stay high for one more step. The high time averaged over a period therefore has 12-bit resolution, while the output still repeats at the subsection rate, so a downstream low-pass filter sees a fast ripple.

The duty word is sampled only at the first step of each period. The block then pulses `cycle_start` for one clock, so the source of the duty word knows that a new period has begun and can prepare the word for the next one. The four fractional bits spread their extra steps evenly by weight. The most significant bit adds a step to every odd subsection, the next bit to every subsection whose index is 2 modulo 4, the next to subsections 4 and 12, and the least significant bit to subsection 8. Subsection 0 never gets an extra step.

Top module: `pwmd_top`

## Requirements
- R1: While `rst` is high, and after it falls until the first tick, `pwm_out` and `cycle_start` are 0.
- R2: A period is exactly 4096 ticks long. `cycle_start` is a one-clock pulse in the clock after the tick that starts step 0 of subsection 0, and successive pulses are 4096 ticks apart.
- R3: In every subsection the output is high for a contiguous run of steps starting at step 0 and low for the rest of the subsection. Each step's level appears on `pwm_out` in the clock after its tick.
- R4: The high length of subsection s is D[11:4] plus one extra step when the fractional field D[3:0] selects s. D[3] selects every odd s, D[2] selects s in {2,6,10,14}, D[1] selects s in {4,12}, D[0] selects s = 8, and s = 0 is never selected. For example, D = 0x4A6 gives 74 steps in ten subsections and 75 in subsections 2, 4, 6, 10, 12 and 14.
- R5: With D[3:0] = 0 every subsection has the same high length, D[11:4].
- R6: With D[11:4] = 255 the extra step is suppressed, so every subsection ends with at least one low step and the output is never high for a whole period.
- R7: A duty word is captured only on the tick that starts a period. Changes to `duty_in` at any other time have no effect on the period in progress.
- R8: In a clock without a tick, `pwm_out` keeps its value and `cycle_start` stays low.
- R9: For D[11:4] < 255, the total high time over one period is 16·D[11:4] + D[3:0] steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Clock enable; each clock with it high advances one time step |
| duty_in | input | 12 | Duty word: [11:4] base high steps, [3:0] fractional selection |
| pwm_out | output | 1 | Registered PWM output |
| cycle_start | output | 1 | One-clock pulse marking the start of a period |

## Verification
The hardest case to reach from the ports is a duty word that changes in the middle of a period. The wrong period then shows only as a small shift in the high-step count, and only if the two words differ in their fractional bits. For each period the stimulus writes a random word and then the intended word, both well after `cycle_start`. The scoreboard expects the word in place at the next boundary and counts high steps in each of the 16 subsections. Tick gaps are random in some periods, and the words include nibble 0, base 255 with a nonzero nibble, and 0x4A6.

// File: rtl/pwmd_pkg.sv
package pwmd_pkg;

    localparam int unsigned SUB_BITS         = 4;
    localparam int unsigned STEP_BITS        = 8;
    localparam int unsigned DUTY_BITS        = SUB_BITS + STEP_BITS;
    localparam int unsigned NUM_SUBS         = 1 << SUB_BITS;
    localparam int unsigned STEPS_PER_SUB    = 1 << STEP_BITS;
    localparam int unsigned STEPS_PER_PERIOD = NUM_SUBS * STEPS_PER_SUB;

    typedef logic [SUB_BITS-1:0]  sub_t;
    typedef logic [STEP_BITS-1:0] step_t;

    // Position of the step about to be emitted.
    typedef struct packed {
        sub_t  sub;
        step_t step;
    } pos_t;

    // Duty word layout: base high length above the fractional selector.
    typedef struct packed {
        step_t base;
        sub_t  frac;
    } duty_t;

    // The lowest set bit of the subsection index picks which fractional bit
    // governs it: index bit k maps to fraction bit (SUB_BITS-1-k).
    function automatic logic dither_pick(sub_t s, sub_t frac);
        logic pick;
        logic found;
        pick  = 1'b0;
        found = 1'b0;
        for (int k = 0; k < int'(SUB_BITS); k++) begin
            if (!found && s[k]) begin
                found = 1'b1;
                pick  = frac[int'(SUB_BITS) - 1 - k];
            end
        end
        return pick;
    endfunction

    // High length of one subsection; a full-scale base never gets the bump.
    function automatic step_t sub_high_len(sub_t s, duty_t d);
        logic bump;
        bump = dither_pick(s, d.frac) && (d.base != '1);
        return d.base + step_t'(bump);
    endfunction

    function automatic logic level_at(pos_t p, duty_t d);
        return p.step < sub_high_len(p.sub, d);
    endfunction

endpackage

// File: rtl/pwmd_timebase.sv
module pwmd_timebase
    import pwmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output pos_t pos,
    output logic at_origin
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (tick) begin
            pos.step <= pos.step + 1'b1;
            if (pos.step == '1) begin
                pos.sub <= pos.sub + 1'b1;
            end
        end
    end

    assign at_origin = (pos == '0);

endmodule

// File: rtl/pwmd_duty_latch.sv
module pwmd_duty_latch
    import pwmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 at_origin,
    input  logic [DUTY_BITS-1:0] duty_in,
    output duty_t                held,
    output duty_t                eff
);

    logic  load;
    duty_t incoming;

    assign load     = tick && at_origin;
    assign incoming = duty_t'(duty_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (load) begin
            held <= incoming;
        end
    end

    // Step 0 of a period already uses the word being captured.
    assign eff = at_origin ? incoming : held;

endmodule

// File: rtl/pwmd_shaper.sv
module pwmd_shaper
    import pwmd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  at_origin,
    input  pos_t  pos,
    input  duty_t eff,
    output logic  pwm_q,
    output logic  start_q
);

    logic next_level;

    assign next_level = level_at(pos, eff);

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_q   <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= tick && at_origin;
            if (tick) begin
                pwm_q <= next_level;
            end
        end
    end

endmodule

// File: rtl/pwmd_top.sv
module pwmd_top
    import pwmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [DUTY_BITS-1:0] duty_in,
    output logic                 pwm_out,
    output logic                 cycle_start
);

    pos_t  pos;
    logic  at_origin;
    duty_t duty_held;
    duty_t duty_eff;

    pwmd_timebase u_timebase (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .pos       (pos),
        .at_origin (at_origin)
    );

    pwmd_duty_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .at_origin (at_origin),
        .duty_in   (duty_in),
        .held      (duty_held),
        .eff       (duty_eff)
    );

    pwmd_shaper u_shaper (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .at_origin (at_origin),
        .pos       (pos),
        .eff       (duty_eff),
        .pwm_q     (pwm_out),
        .start_q   (cycle_start)
    );

endmodule

// File: rtl/pwmd_checker.sv
module pwmd_checker
    import pwmd_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  tick,
    input logic  pwm_out,
    input logic  cycle_start,
    input pos_t  pos,
    input logic  at_origin,
    input duty_t held
);

    logic               tick_d;
    logic               seen;
    logic [DUTY_BITS:0] span;

    // Ticks since the previous strobe, inclusive of the strobe's own tick.
    always_ff @(posedge clk) begin
        if (rst) begin
            tick_d <= 1'b0;
            seen   <= 1'b0;
            span   <= '0;
        end else begin
            tick_d <= tick;
            if (cycle_start) begin
                seen <= 1'b1;
                span <= (DUTY_BITS+1)'(1);
            end else if (tick_d) begin
                span <= span + 1'b1;
            end
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!pwm_out && !cycle_start));

    p_period_span_r2: assert property (@(posedge clk) disable iff (rst)
        (cycle_start && seen) |-> (span == (DUTY_BITS+1)'(STEPS_PER_PERIOD)));

    p_single_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        cycle_start |=> !cycle_start);

    p_last_step_low_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && (pos.step == '1)) |=> !pwm_out);

    p_load_at_origin_r7: assert property (@(posedge clk) disable iff (rst)
        !(tick && at_origin) |=> $stable(held));

    p_hold_between_ticks_r8: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(pwm_out) && !cycle_start));

endmodule

bind pwmd_top pwmd_checker u_pwmd_checker (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .pwm_out     (pwm_out),
    .cycle_start (cycle_start),
    .pos         (pos),
    .at_origin   (at_origin),
    .held        (duty_held)
);

// File: tb/tb_pwmd_top.sv
module tb_pwmd_top;

    localparam int NWORDS = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [11:0] duty_in = '0;
    logic        pwm_out;
    logic        cycle_start;

    int checks = 0;
    int errors = 0;
    bit run = 1'b0;
    bit done = 1'b0;
    bit gap_mode = 1'b0;

    logic [11:0] exp_q[$];
    logic [11:0] words[NWORDS];

    always #2 clk = ~clk;

    pwmd_top dut (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .duty_in     (duty_in),
        .pwm_out     (pwm_out),
        .cycle_start (cycle_start)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected high length per subsection, written from the requirement text.
    function automatic int exp_len(int s, logic [11:0] d);
        int   base;
        logic bump;
        base = int'(d[11:4]);
        if (s == 0)          bump = 1'b0;
        else if (s % 2 == 1) bump = d[3];
        else if (s % 4 == 2) bump = d[2];
        else if (s % 8 == 4) bump = d[1];
        else                 bump = d[0];
        if (base == 255) bump = 1'b0;
        return base + (bump ? 1 : 0);
    endfunction

    // Tick generator: steady or randomly gapped.
    initial begin
        wait (run);
        while (!done) begin
            @(posedge clk);
            #1;
            tick = gap_mode ? ($urandom_range(3) != 0) : 1'b1;
        end
    end

    // Monitor / scoreboard.
    bit          pend = 1'b0;
    bit          active = 1'b0;
    bit          seen_cs = 1'b0;
    bit          r8_bad = 1'b0;
    logic        prev_pwm = 1'b0;
    logic [11:0] cur = '0;
    int          sub = 0;
    int          step = 0;
    int          tick_span = 0;
    int          hi_cnt[16];
    bit          shape_bad[16];

    task automatic finalize();
        int    total;
        int    exp_total;
        string req;
        total = 0;
        exp_total = 0;
        for (int s = 0; s < 16; s++) begin
            if (cur[11:4] == 8'hFF)      req = "R6";
            else if (cur[3:0] == 4'h0)  req = "R5";
            else                        req = "R4";
            check(hi_cnt[s] == exp_len(s, cur), req, $sformatf("high steps word %h sub %0d", cur, s),
                  hi_cnt[s], exp_len(s, cur));
            check(!shape_bad[s], "R3", $sformatf("contiguous high word %h sub %0d", cur, s),
                  int'(shape_bad[s]), 0);
            total += hi_cnt[s];
            exp_total += exp_len(s, cur);
        end
        // R7: a mid-period word leaking in would shift this total; R9 formula.
        if (cur[11:4] != 8'hFF)
            exp_total = 16 * int'(cur[11:4]) + int'(cur[3:0]);
        check(total == exp_total, "R7,R9", $sformatf("period total word %h", cur), total, exp_total);
        check(total < 4096, "R6", "never high for a whole period", total, 4095);
        check(!r8_bad, "R8", "output moved without a tick", int'(r8_bad), 0);
        r8_bad = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (cycle_start) begin
                if (seen_cs)
                    check(tick_span == 4096, "R2", "ticks per period", tick_span, 4096);
                if (active) finalize();
                active = (exp_q.size() > 0);
                if (active) cur = exp_q.pop_front();
                seen_cs   = 1'b1;
                tick_span = 0;
                sub       = 0;
                step      = 0;
                for (int s = 0; s < 16; s++) begin
                    hi_cnt[s]    = 0;
                    shape_bad[s] = 1'b0;
                end
            end
            if (pend) begin
                tick_span++;
                if (active) begin
                    if (pwm_out) hi_cnt[sub]++;
                    if (pwm_out != (step < exp_len(sub, cur))) shape_bad[sub] = 1'b1;
                end
                step++;
                if (step == 256) begin
                    step = 0;
                    sub  = (sub + 1) % 16;
                end
            end else if (seen_cs && ((pwm_out !== prev_pwm) || cycle_start)) begin
                r8_bad = 1'b1;
            end
            prev_pwm = pwm_out;
        end
        pend = tick;
    end

    // Driver.
    initial begin
        words[0]  = 12'h4A6;
        words[1]  = 12'h000;
        words[2]  = 12'hFFF;
        words[3]  = 12'h800;
        words[4]  = 12'h00F;
        words[5]  = 12'h001;
        words[6]  = 12'hFF0;
        words[7]  = 12'hFE9;
        words[8]  = 12'h7F8;
        for (int i = 9; i < NWORDS; i++) words[i] = 12'($urandom);

        repeat (4) @(posedge clk);
        @(negedge clk);
        check(pwm_out == 1'b0 && cycle_start == 1'b0, "R1", "outputs during reset",
              int'({pwm_out, cycle_start}), 0);
        @(posedge clk);
        #1 rst = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(pwm_out == 1'b0 && cycle_start == 1'b0, "R1", "outputs before first tick",
              int'({pwm_out, cycle_start}), 0);

        @(posedge clk);
        #1 duty_in = words[0];
        exp_q.push_back(words[0]);
        run = 1'b1;

        for (int i = 1; i < NWORDS; i++) begin
            @(posedge cycle_start);
            gap_mode = (i % 3 == 0);
            repeat (100 + 37 * i) @(posedge clk);
            #1 duty_in = 12'($urandom);
            repeat (60) @(posedge clk);
            #1 duty_in = words[i];
            exp_q.push_back(words[i]);
        end
        @(posedge cycle_start);
        @(posedge cycle_start);
        repeat (3) @(negedge clk);
        done = 1'b1;
        check(exp_q.size() == 0, "R2", "all queued periods observed", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, got %0d expected %0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule